// File: doc/BRIEF.md
# Platform System Control Register Bank

This block is a byte-wide bank of control and identification registers on a synchronous I/O port bus. A bus master presents a port address with a read or a write strobe. Writes update a few control bits or scratch bytes, or fire one-cycle strobes. Reads return stored values, fixed identification and status bytes, or all ones for ports that have no content.

Several control bits leave the block as levels for other logic to use. These are a soft-reset request, a byte-order mode flag, a disk activity light and an I/O map-type select. Two lock-toggle strobes go to an external non-volatile memory. A one-cycle error flag marks any write to an address that the bank does not decode.

The decoded set has three parts: the legacy port 0x092, the scratch bytes at 0x398 and 0x399, and the window 0x800 to 0x851. Read data is registered and comes back, together with a valid flag, in the cycle after the read strobe.

Top module: `sysreg_bank`

## Requirements
- R1: While reset is high, and after it, every stored item is zero. This covers soft_reset, little_endian, disk_light, map_noncontig, the system control value and both scratch bytes. The strobe outputs and wr_err are also low.
- R2: A write to port 0x092 drives soft_reset to data bit 0 and little_endian to data bit 1. Both take effect from the cycle after the write and hold that level until the next write to 0x092. A read of 0x092 returns 0x00.
- R3: A write to port 0x808 sets disk_light to data bit 0 and changes no other stored bit.
- R4: A write to port 0x81C keeps only data bits 3:0 as the system control value. A read of 0x81C returns that value with bits 7:4 zero.
- R5: A write to port 0x850 stores data bit 0 as map_noncontig, where 0 means contiguous and 1 means non-contiguous. A read of 0x850 returns the bit in position 0, with all other bits zero.
- R6: A write to 0x810 raises nvram_lock1, and a write to 0x812 raises nvram_lock2. Each strobe is high for exactly the one cycle after the write, and the other strobe stays low.
- R7: Reads of the fixed ports return these constants: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00 and 0x823 gives 0x03.
- R8: A read of an address that R2 to R7 and R9 do not list returns 0xFF. This covers both decoded and undecoded addresses, including 0x808, 0x812 and 0x814. A write to 0x800, 0x802, 0x803, 0x814 or any other listless port inside the 0x800 to 0x851 window changes nothing and raises no error.
- R9: Ports 0x398 and 0x399 are two independent bytes of read/write storage.
- R10: A write to an address outside the decoded set raises wr_err for the one cycle after the write and leaves all stored state unchanged.
- R11: io_rvalid is high exactly in the cycle after a cycle with io_rd high, and io_rdata carries the value for the address sampled with that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | Port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_rvalid | output | 1 | Read data valid, one cycle after io_rd |
| soft_reset | output | 1 | Level soft-reset request |
| little_endian | output | 1 | Byte-order mode flag |
| disk_light | output | 1 | Disk activity light state |
| map_noncontig | output | 1 | I/O map type, 1 means non-contiguous |
| nvram_lock1 | output | 1 | One-cycle lock-toggle strobe 1 |
| nvram_lock2 | output | 1 | One-cycle lock-toggle strobe 2 |
| wr_err | output | 1 | One-cycle undecoded-write flag |

## Verification
The properties assume that a write and a read never target the same port in the same cycle. They also assume that the strobes and address are free of X once reset is released, since the lock-strobe and level-hold checks trace each output change back to one write in the previous cycle. The stimulus changes inputs only on the falling clock edge and holds them for a full cycle. It never raises io_wr and io_rd together. It keeps both strobes low during reset.

// File: rtl/sysreg_pkg.sv
`timescale 1ns/1ps
package sysreg_pkg;

    localparam int DATA_W = 8;
    localparam int PORT_W = 16;

    // Port map; positions are part of the bus contract
    localparam logic [PORT_W-1:0] P_RSTCTL  = 16'h0092;
    localparam logic [PORT_W-1:0] P_SCRATCH = 16'h0398;
    localparam logic [PORT_W-1:0] P_WIN_LO  = 16'h0800;
    localparam logic [PORT_W-1:0] P_WIN_HI  = 16'h0851;
    localparam logic [PORT_W-1:0] P_CPUID   = 16'h0800;
    localparam logic [PORT_W-1:0] P_FEAT    = 16'h0802;
    localparam logic [PORT_W-1:0] P_BSTAT   = 16'h0803;
    localparam logic [PORT_W-1:0] P_LIGHT   = 16'h0808;
    localparam logic [PORT_W-1:0] P_EQUIP   = 16'h080C;
    localparam logic [PORT_W-1:0] P_LOCK1   = 16'h0810;
    localparam logic [PORT_W-1:0] P_LOCK2   = 16'h0812;
    localparam logic [PORT_W-1:0] P_L2INV   = 16'h0814;
    localparam logic [PORT_W-1:0] P_KEY     = 16'h0818;
    localparam logic [PORT_W-1:0] P_SYSCTL  = 16'h081C;
    localparam logic [PORT_W-1:0] P_L2STAT  = 16'h0823;
    localparam logic [PORT_W-1:0] P_MAPTYP  = 16'h0850;

    // Fixed read bytes
    localparam logic [DATA_W-1:0] V_CPUID  = 8'hEF;
    localparam logic [DATA_W-1:0] V_FEAT   = 8'hAD;
    localparam logic [DATA_W-1:0] V_BSTAT  = 8'hE0;
    localparam logic [DATA_W-1:0] V_EQUIP  = 8'h3C;
    localparam logic [DATA_W-1:0] V_EXTFT  = 8'h39;
    localparam logic [DATA_W-1:0] V_KEY    = 8'h00;
    localparam logic [DATA_W-1:0] V_L2STAT = 8'h03;
    localparam logic [DATA_W-1:0] V_EMPTY  = 8'hFF;

    localparam int SYSCTL_W = 4;

    typedef enum logic [4:0] {
        SEL_NONE,      // outside decoded set
        SEL_RSTCTL,
        SEL_SCRATCH,
        SEL_CPUID,
        SEL_FEAT,
        SEL_BSTAT,
        SEL_LIGHT,
        SEL_EQUIP,
        SEL_LOCK1,
        SEL_LOCK2,
        SEL_L2INV,
        SEL_KEY,
        SEL_SYSCTL,
        SEL_L2STAT,
        SEL_MAPTYP,
        SEL_WIN_EMPTY  // inside window, no content
    } sel_e;

    typedef struct packed {
        logic                soft_rst;
        logic                le_mode;
        logic                light;
        logic                map_nc;
        logic [SYSCTL_W-1:0] sysctl;
    } ctrl_t;

    function automatic sel_e window_sel(input logic [PORT_W-1:0] p);
        case (p)
            P_CPUID:  return SEL_CPUID;
            P_FEAT:   return SEL_FEAT;
            P_BSTAT:  return SEL_BSTAT;
            P_LIGHT:  return SEL_LIGHT;
            P_EQUIP:  return SEL_EQUIP;
            P_LOCK1:  return SEL_LOCK1;
            P_LOCK2:  return SEL_LOCK2;
            P_L2INV:  return SEL_L2INV;
            P_KEY:    return SEL_KEY;
            P_SYSCTL: return SEL_SYSCTL;
            P_L2STAT: return SEL_L2STAT;
            P_MAPTYP: return SEL_MAPTYP;
            default:  return SEL_WIN_EMPTY;
        endcase
    endfunction

endpackage

// File: rtl/sysreg_decode.sv
`timescale 1ns/1ps
module sysreg_decode
    import sysreg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SCR_N  = 2,
    localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [SCR_IW-1:0] scr_idx
);

    localparam logic [PORT_W-1:0] SCR_END = PORT_W'(int'(P_SCRATCH) + SCR_N);

    logic              hi_ok;
    logic [PORT_W-1:0] lo;
    logic [PORT_W-1:0] scr_off;

    assign lo      = addr[PORT_W-1:0];
    assign scr_off = lo - P_SCRATCH;

    generate
        if (ADDR_W > PORT_W) begin : g_wide
            assign hi_ok = ~|addr[ADDR_W-1:PORT_W];
        end else begin : g_narrow
            assign hi_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        sel     = SEL_NONE;
        scr_idx = '0;
        if (hi_ok) begin
            if (lo == P_RSTCTL) begin
                sel = SEL_RSTCTL;
            end else if (lo >= P_SCRATCH && lo < SCR_END) begin
                sel     = SEL_SCRATCH;
                scr_idx = scr_off[SCR_IW-1:0];
            end else if (lo >= P_WIN_LO && lo <= P_WIN_HI) begin
                sel = window_sel(lo);
            end
        end
    end

endmodule

// File: rtl/sysreg_ctrl.sv
`timescale 1ns/1ps
module sysreg_ctrl
    import sysreg_pkg::*;
#(
    parameter int SCR_N  = 2,
    localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr,
    input  sel_e                         sel,
    input  logic [SCR_IW-1:0]            scr_idx,
    input  logic [DATA_W-1:0]            wdata,
    output ctrl_t                        st,
    output logic [SCR_N-1:0][DATA_W-1:0] scratch,
    output logic                         lock1,
    output logic                         lock2,
    output logic                         err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            lock1 <= 1'b0;
            lock2 <= 1'b0;
            err   <= 1'b0;
        end else begin
            lock1 <= 1'b0;
            lock2 <= 1'b0;
            err   <= 1'b0;
            if (wr) begin
                case (sel)
                    SEL_RSTCTL: begin
                        st.soft_rst <= wdata[0];
                        st.le_mode  <= wdata[1];
                    end
                    SEL_LIGHT:  st.light  <= wdata[0];
                    SEL_SYSCTL: st.sysctl <= wdata[SYSCTL_W-1:0];
                    SEL_MAPTYP: st.map_nc <= wdata[0];
                    SEL_LOCK1:  lock1     <= 1'b1;
                    SEL_LOCK2:  lock2     <= 1'b1;
                    SEL_NONE:   err       <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    generate
        for (genvar g = 0; g < SCR_N; g++) begin : g_scr
            always_ff @(posedge clk) begin
                if (rst) begin
                    scratch[g] <= '0;
                end else if (wr && sel == SEL_SCRATCH && scr_idx == SCR_IW'(g)) begin
                    scratch[g] <= wdata;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sysreg_rdmux.sv
`timescale 1ns/1ps
module sysreg_rdmux
    import sysreg_pkg::*;
#(
    parameter int SCR_N  = 2,
    localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd,
    input  sel_e                         sel,
    input  logic [SCR_IW-1:0]            scr_idx,
    input  ctrl_t                        st,
    input  logic [SCR_N-1:0][DATA_W-1:0] scratch,
    output logic [DATA_W-1:0]            rdata,
    output logic                         rvalid
);

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        case (sel)
            SEL_RSTCTL:  rd_next = '0;
            SEL_SCRATCH: rd_next = scratch[scr_idx];
            SEL_CPUID:   rd_next = V_CPUID;
            SEL_FEAT:    rd_next = V_FEAT;
            SEL_BSTAT:   rd_next = V_BSTAT;
            SEL_EQUIP:   rd_next = V_EQUIP;
            SEL_LOCK1:   rd_next = V_EXTFT;
            SEL_KEY:     rd_next = V_KEY;
            SEL_SYSCTL:  rd_next = {{(DATA_W-SYSCTL_W){1'b0}}, st.sysctl};
            SEL_L2STAT:  rd_next = V_L2STAT;
            SEL_MAPTYP:  rd_next = {{(DATA_W-1){1'b0}}, st.map_nc};
            default:     rd_next = V_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) begin
                rdata <= rd_next;
            end
        end
    end

endmodule

// File: rtl/sysreg_bank.sv
`timescale 1ns/1ps
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SCR_N  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rvalid,
    output logic              soft_reset,
    output logic              little_endian,
    output logic              disk_light,
    output logic              map_noncontig,
    output logic              nvram_lock1,
    output logic              nvram_lock2,
    output logic              wr_err
);

    localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1;

    sel_e                         sel;
    logic [SCR_IW-1:0]            scr_idx;
    ctrl_t                        st;
    logic [SCR_N-1:0][DATA_W-1:0] scratch;

    sysreg_decode #(.ADDR_W(ADDR_W), .SCR_N(SCR_N)) u_dec (
        .addr    (io_addr),
        .sel     (sel),
        .scr_idx (scr_idx)
    );

    sysreg_ctrl #(.SCR_N(SCR_N)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (io_wr),
        .sel     (sel),
        .scr_idx (scr_idx),
        .wdata   (io_wdata),
        .st      (st),
        .scratch (scratch),
        .lock1   (nvram_lock1),
        .lock2   (nvram_lock2),
        .err     (wr_err)
    );

    sysreg_rdmux #(.SCR_N(SCR_N)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd      (io_rd),
        .sel     (sel),
        .scr_idx (scr_idx),
        .st      (st),
        .scratch (scratch),
        .rdata   (io_rdata),
        .rvalid  (io_rvalid)
    );

    assign soft_reset    = st.soft_rst;
    assign little_endian = st.le_mode;
    assign disk_light    = st.light;
    assign map_noncontig = st.map_nc;

endmodule

// File: rtl/sysreg_bank_chk.sv
`timescale 1ns/1ps
module sysreg_bank_chk
    import sysreg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              io_rvalid,
    input logic              soft_reset,
    input logic              little_endian,
    input logic              disk_light,
    input logic              map_noncontig,
    input logic              nvram_lock1,
    input logic              nvram_lock2,
    input logic              wr_err
);

    // R2
    rst_level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(soft_reset) |-> $past(io_wr && io_addr == ADDR_W'(P_RSTCTL)));

    // R2
    endian_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(little_endian) |-> $past(io_wr && io_addr == ADDR_W'(P_RSTCTL)));

    // R3
    light_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(disk_light) |-> $past(io_wr && io_addr == ADDR_W'(P_LIGHT)));

    // R6
    lock1_src_chk: assert property (@(posedge clk) disable iff (rst)
        nvram_lock1 |-> $past(io_wr && io_addr == ADDR_W'(P_LOCK1)));

    // R6
    lock2_src_chk: assert property (@(posedge clk) disable iff (rst)
        nvram_lock2 |-> $past(io_wr && io_addr == ADDR_W'(P_LOCK2)));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nvram_lock1, nvram_lock2, wr_err}));

    // R10
    err_src_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(io_wr));

    // R11
    rvalid_on_chk: assert property (@(posedge clk) disable iff (rst)
        io_rd |=> io_rvalid);

    // R11
    rvalid_off_chk: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> !io_rvalid);

    // R7
    cpuid_val_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == ADDR_W'(P_CPUID)) |=> io_rdata == V_CPUID);

    // R4
    sysctl_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == ADDR_W'(P_SYSCTL)) |=> io_rdata[7:4] == 4'h0);

endmodule

bind sysreg_bank sysreg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sysreg_bank_tb.sv
`timescale 1ns/1ps
module sysreg_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic        soft_reset, little_endian, disk_light, map_noncontig;
    logic        nvram_lock1, nvram_lock2, wr_err;

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    sysreg_bank u_dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
        .soft_reset(soft_reset), .little_endian(little_endian),
        .disk_light(disk_light), .map_noncontig(map_noncontig),
        .nvram_lock1(nvram_lock1), .nvram_lock2(nvram_lock2), .wr_err(wr_err)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one write, returns on the falling edge after the capturing edge
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        io_rd = 1'b1; io_addr = a;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    // monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (!rst && io_rvalid) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R11 unexpected rvalid: actual 1 expected 0");
            end else begin
                chk(tag_q.pop_front(), io_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog R11: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 soft_reset in reset", {7'b0, soft_reset}, 8'h00);
        rst = 1'b0;
        chk("R1 outputs after reset",
            {1'b0, soft_reset, little_endian, disk_light, map_noncontig,
             nvram_lock1, nvram_lock2, wr_err}, 8'h00);
        chk("R11 rvalid idle", {7'b0, io_rvalid}, 8'h00);
        rd(16'h081C, 8'h00, "R1 sysctl reset");
        rd(16'h0850, 8'h00, "R1 map reset");
        rd(16'h0398, 8'h00, "R1 R9 scratch0 reset");
        rd(16'h0399, 8'h00, "R1 R9 scratch1 reset");

        // R2 legacy port
        wr(16'h0092, 8'h03);
        chk("R2 soft_reset set", {7'b0, soft_reset}, 8'h01);
        chk("R2 endian set", {7'b0, little_endian}, 8'h01);
        repeat (4) idle();
        chk("R2 soft_reset level held", {7'b0, soft_reset}, 8'h01);
        rd(16'h0092, 8'h00, "R2 read port 92");
        wr(16'h0092, 8'h02);
        chk("R2 soft_reset cleared", {7'b0, soft_reset}, 8'h00);
        chk("R2 endian kept", {7'b0, little_endian}, 8'h01);
        wr(16'h0092, 8'hFD);
        chk("R2 bit0 only", {6'b0, little_endian, soft_reset}, 8'h01);
        wr(16'h0092, 8'h00);
        chk("R2 both clear", {6'b0, little_endian, soft_reset}, 8'h00);

        // R3 light
        wr(16'h0808, 8'hFF);
        chk("R3 light set", {7'b0, disk_light}, 8'h01);
        chk("R3 others untouched", {5'b0, soft_reset, little_endian, map_noncontig}, 8'h00);
        rd(16'h081C, 8'h00, "R3 sysctl untouched");
        wr(16'h0808, 8'hFE);
        chk("R3 light clear", {7'b0, disk_light}, 8'h00);

        // R4 system control
        wr(16'h081C, 8'hA7);
        rd(16'h081C, 8'h07, "R4 low nibble A7");
        wr(16'h081C, 8'hFC);
        rd(16'h081C, 8'h0C, "R4 low nibble FC");

        // R5 map type
        wr(16'h0850, 8'h03);
        chk("R5 map set", {7'b0, map_noncontig}, 8'h01);
        rd(16'h0850, 8'h01, "R5 map read 1");
        wr(16'h0850, 8'hFE);
        chk("R5 map clear", {7'b0, map_noncontig}, 8'h00);
        rd(16'h0850, 8'h00, "R5 map read 0");

        // R6 lock strobes
        wr(16'h0810, 8'h00);
        chk("R6 lock1 pulse", {6'b0, nvram_lock1, nvram_lock2}, 8'h02);
        idle();
        chk("R6 lock1 one cycle", {6'b0, nvram_lock1, nvram_lock2}, 8'h00);
        wr(16'h0812, 8'h55);
        chk("R6 lock2 pulse", {6'b0, nvram_lock1, nvram_lock2}, 8'h01);
        idle();
        chk("R6 lock2 one cycle", {6'b0, nvram_lock1, nvram_lock2}, 8'h00);

        // R7 fixed values
        rd(16'h0800, 8'hEF, "R7 0x800");
        rd(16'h0802, 8'hAD, "R7 0x802");
        rd(16'h0803, 8'hE0, "R7 0x803");
        rd(16'h080C, 8'h3C, "R7 0x80C");
        rd(16'h0810, 8'h39, "R7 0x810");
        rd(16'h0818, 8'h00, "R7 0x818");
        rd(16'h0823, 8'h03, "R7 0x823");

        // R8 empty reads and ignored writes
        rd(16'h0801, 8'hFF, "R8 0x801");
        rd(16'h0808, 8'hFF, "R8 0x808");
        rd(16'h0812, 8'hFF, "R8 0x812");
        rd(16'h0814, 8'hFF, "R8 0x814");
        rd(16'h0851, 8'hFF, "R8 0x851");
        rd(16'h1234, 8'hFF, "R8 undecoded read");
        wr(16'h0800, 8'h00);
        chk("R8 write 0x800 no err", {7'b0, wr_err}, 8'h00);
        wr(16'h0802, 8'hFF);
        wr(16'h0803, 8'hFF);
        wr(16'h0814, 8'hFF);
        chk("R8 write 0x814 no err", {7'b0, wr_err}, 8'h00);
        wr(16'h0801, 8'hFF);
        chk("R8 window write no effect",
            {1'b0, soft_reset, little_endian, disk_light, map_noncontig,
             nvram_lock1, nvram_lock2, wr_err}, 8'h00);
        rd(16'h0800, 8'hEF, "R8 0x800 unchanged");
        rd(16'h0803, 8'hE0, "R8 0x803 unchanged");
        rd(16'h081C, 8'h0C, "R8 sysctl unchanged");

        // R9 scratch
        wr(16'h0398, 8'h5A);
        wr(16'h0399, 8'hC3);
        rd(16'h0398, 8'h5A, "R9 scratch0");
        rd(16'h0399, 8'hC3, "R9 scratch1");
        wr(16'h0399, 8'h11);
        rd(16'h0398, 8'h5A, "R9 scratch0 kept");
        rd(16'h0399, 8'h11, "R9 scratch1 rewritten");

        // R10 undecoded writes
        wr(16'h1234, 8'hFF);
        chk("R10 err pulse 0x1234", {7'b0, wr_err}, 8'h01);
        idle();
        chk("R10 err one cycle", {7'b0, wr_err}, 8'h00);
        wr(16'h0852, 8'h01);
        chk("R10 err pulse 0x852", {7'b0, wr_err}, 8'h01);
        wr(16'h039A, 8'hFF);
        chk("R10 err pulse 0x39A", {7'b0, wr_err}, 8'h01);
        wr(16'h0093, 8'h03);
        chk("R10 err pulse 0x093", {7'b0, wr_err}, 8'h01);
        chk("R10 state unchanged",
            {4'b0, soft_reset, little_endian, disk_light, map_noncontig}, 8'h00);
        rd(16'h0398, 8'h5A, "R10 scratch unchanged");

        // R11 back-to-back reads
        @(negedge clk);
        exp_q.push_back(8'hAD); tag_q.push_back("R11 burst first");
        io_rd = 1'b1; io_addr = 16'h0802;
        @(negedge clk);
        exp_q.push_back(8'h11); tag_q.push_back("R11 burst second");
        io_addr = 16'h0399;
        @(negedge clk);
        io_rd = 1'b0;
        idle();
        chk("R11 rvalid drops", {7'b0, io_rvalid}, 8'h00);

        // R1 reset in mid run
        wr(16'h0092, 8'h03);
        wr(16'h0808, 8'h01);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 re-reset outputs",
            {4'b0, soft_reset, little_endian, disk_light, map_noncontig}, 8'h00);
        rd(16'h081C, 8'h00, "R1 re-reset sysctl");
        rd(16'h0399, 8'h00, "R1 re-reset scratch");

        repeat (3) idle();
        if (exp_q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL R11 missing read data: actual %0d pending expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule